// File: doc/BRIEF.md
# IrDA SIR Pulse Codec

This block sits between a UART core and an infrared optical transceiver. On the transmit path it turns the UART's NRZ serial line into return-to-zero-inverted pulses. Every zero bit, start bits included, becomes a short high pulse that lasts three sixteenths of the bit period. Every one bit, stop bits and idle included, leaves the optical output dark. All transmit timing is counted in the UART's 16x oversampling ticks.

On the receive path the block watches the transceiver output for high-to-low transitions. Each transition opens a one-bit-long low window on the NRZ line toward the UART receiver. The input is assumed to be free of noise already, because filtering is done upstream. When the enable input is low, both paths pass their signals through unchanged, so the UART can talk directly to a wired line.

Top module: `irda_sir_codec`

## Requirements
- R1: After reset is released with the enable high and the NRZ transmit line idle (1), the IR output is low and the NRZ receive output is high.
- R2: When the NRZ transmit line drops to 0 at a tick, the IR output goes high on that tick edge. It stays high for exactly PULSE_TICKS (default 3) ticks and goes low on the following tick edge.
- R3: While the transmitted bit is 1, the IR output stays low for every tick of that bit.
- R4: Consecutive zero bits each get their own pulse. The phase counter wraps every BIT_TICKS (default 16) ticks and starts a new pulse without any transition on the NRZ line.
- R5: A high-to-low transition on the IR receive input drives the NRZ receive output low within one clock cycle. The output stays low until exactly BIT_TICKS ticks have elapsed and then returns high. The low window ends only on a tick.
- R6: A new falling edge inside an open window restarts the window, so the output stays low until BIT_TICKS ticks after the latest edge.
- R7: A high level or a rising edge on the IR receive input never opens a window. With the input held high, the NRZ receive output stays high.
- R8: With the enable low, the IR output equals the NRZ transmit line and the NRZ receive output equals the IR receive input. Both encoder and decoder state are cleared. In the first cycle after the enable returns high, the IR output is low and the NRZ receive output is high.
- R9: With the IR output looped back to the IR receive input, a UART frame is recovered bit-exactly. The frame is a start bit of 0, eight data bits with the least significant bit first, and a stop bit of 1. Each bit is recovered when the NRZ receive output is sampled 12 ticks into the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1: encode and decode; 0: pass through |
| tick_i | input | 1 | One-cycle 16x oversampling strobe from the UART |
| nrz_tx_i | input | 1 | NRZ serial data from the UART transmitter |
| ir_tx_o | output | 1 | Pulse output to the optical transmitter |
| ir_rx_i | input | 1 | Pulse input from the optical receiver, already filtered |
| nrz_rx_o | output | 1 | NRZ serial data to the UART receiver |

## Verification
The encoder is checked tick by tick against a model of the expected pulse. The patterns are the all-zero byte, which exercises back-to-back pulses carried by phase wrap only, the all-one byte, which keeps the output dark, alternating bits, and seeded random bytes in a loopback that also proves the decoder window lines up with real pulses. The decoder is also driven directly. Tests cover a single edge, which measures the window length, a second edge ten ticks into a window, which separates a restart from a plain countdown, and a long high level, which separates edge detection from level sampling. Finally, pass-through mode is toggled with stale activity on both inputs, to show that state is cleared on re-enable.

// File: rtl/irda_pkg.sv
package irda_pkg;
  localparam int unsigned SIR_BIT_TICKS   = 16;
  localparam int unsigned SIR_PULSE_TICKS = 3;
endpackage

// File: rtl/irda_sir_mod.sv
module irda_sir_mod #(
  parameter int unsigned BIT_TICKS   = 16,
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic nrz_i,
  output logic pulse_o
);
  localparam int unsigned PH_W = $clog2(BIT_TICKS);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            bit_q;
  logic            pulse_q;

  // bit start: NRZ transition, or wrap of the phase inside a run of equal bits
  always_comb begin
    if (nrz_i != bit_q)                      ph_d = '0;
    else if (ph_q == PH_W'(BIT_TICKS - 1))   ph_d = '0;
    else                                     ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      bit_q   <= 1'b1;
      pulse_q <= 1'b0;
    end else if (!en_i) begin
      ph_q    <= '0;
      bit_q   <= 1'b1;
      pulse_q <= 1'b0;
    end else if (tick_i) begin
      ph_q    <= ph_d;
      bit_q   <= nrz_i;
      pulse_q <= !nrz_i && (ph_d < PH_W'(PULSE_TICKS));
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/irda_sir_demod.sv
module irda_sir_demod #(
  parameter int unsigned BIT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic ir_i,
  output logic nrz_o
);
  localparam int unsigned CNT_W = $clog2(BIT_TICKS + 1);

  logic             rx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall;

  assign fall = rx_q && !ir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      rx_q <= ir_i;
      if (!en_i)                       cnt_q <= '0;
      else if (fall)                   cnt_q <= CNT_W'(BIT_TICKS);  // restart window
      else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign nrz_o = (cnt_q == '0);
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
  parameter int unsigned BIT_TICKS   = irda_pkg::SIR_BIT_TICKS,
  parameter int unsigned PULSE_TICKS = irda_pkg::SIR_PULSE_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic nrz_tx_i,
  output logic ir_tx_o,
  input  logic ir_rx_i,
  output logic nrz_rx_o
);
  logic mod_pulse;
  logic demod_nrz;

  irda_sir_mod #(
    .BIT_TICKS  (BIT_TICKS),
    .PULSE_TICKS(PULSE_TICKS)
  ) u_mod (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick_i),
    .nrz_i  (nrz_tx_i),
    .pulse_o(mod_pulse)
  );

  irda_sir_demod #(
    .BIT_TICKS(BIT_TICKS)
  ) u_demod (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tick_i(tick_i),
    .ir_i  (ir_rx_i),
    .nrz_o (demod_nrz)
  );

  assign ir_tx_o  = en_i ? mod_pulse : nrz_tx_i;
  assign nrz_rx_o = en_i ? demod_nrz : ir_rx_i;
endmodule

// File: rtl/irda_sir_codec_chk.sv
module irda_sir_codec_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tick_i,
  input logic nrz_tx_i,
  input logic ir_tx_o,
  input logic ir_rx_i,
  input logic nrz_rx_o
);
  // R2: a pulse only begins on a tick carrying a zero bit
  a_r2_rise_on_zero_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $rose(ir_tx_o)) |-> ($past(tick_i) && !$past(nrz_tx_i)));

  // R3: a one bit seen on a tick leaves the output dark
  a_r3_one_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && nrz_tx_i) |=> (!ir_tx_o || !en_i));

  // R5: falling edge opens the low window on the next cycle
  a_r5_fall_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $fell(ir_rx_i)) |=> (!nrz_rx_o || !en_i));

  // R5: the window can only close on a tick
  a_r5_close_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !nrz_rx_o && !tick_i) |=> (!nrz_rx_o || !en_i));

  // R8: state cleared when leaving pass-through
  a_r8_clean_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !$past(en_i)) |-> (!ir_tx_o && nrz_rx_o));
endmodule

bind irda_sir_codec irda_sir_codec_chk chk_i (.*);

// File: tb/irda_sir_codec_tb_top.sv
`timescale 1ns/1ps
module irda_sir_codec_tb_top;
  localparam int BIT_TICKS = 16;
  localparam int PULSE     = 3;
  localparam int TICK_DIV  = 4;
  localparam int SAMPLE_AT = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1;
  logic tick_i = 1'b0;
  logic nrz_tx_i = 1'b1;
  logic ir_tx_o;
  logic ir_drv = 1'b0;
  logic loop = 1'b0;
  logic ir_rx;
  logic nrz_rx_o;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign ir_rx = loop ? ir_tx_o : ir_drv;

  irda_sir_codec dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick_i),
    .nrz_tx_i(nrz_tx_i),
    .ir_tx_o (ir_tx_o),
    .ir_rx_i (ir_rx),
    .nrz_rx_o(nrz_rx_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_tx(input logic b, input int p);
    return (b == 1'b0) && (p < PULSE);
  endfunction

  function automatic logic frame_bit(input logic [7:0] d, input int i);
    if (i == 0) return 1'b0;
    if (i == 9) return 1'b1;
    return d[i-1];
  endfunction

  // tick edge: call at a negedge, returns at the next negedge (outputs updated)
  task automatic tick_edge();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic tick_gap();
    repeat (TICK_DIV - 1) @(negedge clk);
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_edge();
      tick_gap();
    end
  endtask

  task automatic send_bit(input logic b, input logic prev, input bit chk_rx);
    nrz_tx_i = b;
    for (int p = 0; p < BIT_TICKS; p++) begin
      tick_edge();
      if (b == 1'b1)                      check(ir_tx_o, exp_tx(b, p), "R3 one bit dark");
      else if (prev == 1'b0 && p < PULSE) check(ir_tx_o, exp_tx(b, p), "R4 repeated zero pulse");
      else                                check(ir_tx_o, exp_tx(b, p), "R2 zero pulse shape");
      if (chk_rx && p == SAMPLE_AT)       check(nrz_rx_o, b, "R9 loopback bit");
      tick_gap();
    end
  endtask

  task automatic send_frame(input logic [7:0] d);
    logic prev = 1'b1;
    for (int i = 0; i < 10; i++) begin
      send_bit(frame_bit(d, i), prev, 1'b1);
      prev = frame_bit(d, i);
    end
  endtask

  // R2: pulse width monitor in loopback, counted in clock cycles
  int run_len = 0;
  always @(negedge clk) begin
    if (rst_ni && en_i && loop) begin
      if (ir_tx_o) run_len++;
      else if (run_len != 0) begin
        vectors++;
        if (run_len != PULSE * TICK_DIV) begin
          errors++;
          $display("FAIL R2 pulse width: actual=%0d expected=%0d clocks", run_len, PULSE * TICK_DIV);
        end
        run_len = 0;
      end
    end else run_len = 0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'hC0DE_5123));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(ir_tx_o, 1'b0, "R1 ir idle after reset");
    check(nrz_rx_o, 1'b1, "R1 nrz idle after reset");
    idle_ticks(4);
    check(ir_tx_o, 1'b0, "R1 ir idle on ticks");

    // decoder, driven directly
    ir_drv = 1'b1; @(negedge clk);
    ir_drv = 1'b0; @(negedge clk);
    check(nrz_rx_o, 1'b0, "R5 low after fall");
    idle_ticks(BIT_TICKS - 1);
    check(nrz_rx_o, 1'b0, "R5 still low before last tick");
    idle_ticks(1);
    check(nrz_rx_o, 1'b1, "R5 high after window");

    ir_drv = 1'b1; @(negedge clk);
    ir_drv = 1'b0; @(negedge clk);
    idle_ticks(10);
    ir_drv = 1'b1; @(negedge clk);
    ir_drv = 1'b0; @(negedge clk);
    idle_ticks(BIT_TICKS - 1);
    check(nrz_rx_o, 1'b0, "R6 window restarted");
    idle_ticks(1);
    check(nrz_rx_o, 1'b1, "R6 window closes after restart");

    ir_drv = 1'b1; @(negedge clk);
    check(nrz_rx_o, 1'b1, "R7 rising edge ignored");
    idle_ticks(20);
    check(nrz_rx_o, 1'b1, "R7 high level ignored");
    ir_drv = 1'b0; @(negedge clk);
    idle_ticks(BIT_TICKS + 1);

    // pass-through
    en_i = 1'b0;
    nrz_tx_i = 1'b0; @(negedge clk);
    check(ir_tx_o, 1'b0, "R8 bypass tx low");
    nrz_tx_i = 1'b1; @(negedge clk);
    check(ir_tx_o, 1'b1, "R8 bypass tx high");
    ir_drv = 1'b1; @(negedge clk);
    check(nrz_rx_o, 1'b1, "R8 bypass rx high");
    ir_drv = 1'b0; @(negedge clk);
    check(nrz_rx_o, 1'b0, "R8 bypass rx low");
    nrz_tx_i = 1'b0;
    ir_drv = 1'b1;
    idle_ticks(5);
    ir_drv = 1'b0;
    idle_ticks(2);
    nrz_tx_i = 1'b1;
    en_i = 1'b1;
    #1;
    check(ir_tx_o, 1'b0, "R8 tx cleared on enable");
    check(nrz_rx_o, 1'b1, "R8 rx cleared on enable");
    @(negedge clk);
    idle_ticks(BIT_TICKS);
    check(ir_tx_o, 1'b0, "R8 no stale pulse");
    check(nrz_rx_o, 1'b1, "R8 no stale window");

    // loopback frames: directed, then random
    loop = 1'b1;
    send_frame(8'h00);
    send_frame(8'hFF);
    send_frame(8'h55);
    send_frame(8'hA3);
    for (int n = 0; n < 24; n++) begin
      b = 8'($urandom);
      send_frame(b);
      idle_ticks(BIT_TICKS * ($urandom % 3));
    end
    idle_ticks(BIT_TICKS + 4);
    check(nrz_rx_o, 1'b1, "R9 loopback idles high");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule